// File: doc/BRIEF.md
# Separated Clock/Data Bit Recovery

This block recovers serial data bits from a disk drive that reports flux reversals on two separate pulse lines, one for clock reversals and one for data reversals. Both lines are assumed to be already synchronized to the system clock and filtered against stutter. Each bit cell is two bit times long. The first half always carries a clock reversal. The second half carries a data reversal only when the bit is a 1.

A detector flag is cleared when the clock line falls and set by any data pulse that follows. When the clock line next rises, the flag is taken as the recovered bit. The bit is reported on a one-cycle strobe and shifted into a word register, most significant bit first. After a parameterized number of bits, the full word is presented with a one-cycle valid strobe. Sector framing and sync-word search belong to logic downstream of this block.

Top module: `sepclk_bit_recover`

## Requirements
- R1: After reset `bit_strobe`, `word_valid` and `word_out` are all zero, and the detector flag is clear.
- R2: An edge on either line is found by comparing the line with its value on the previous cycle. A clock line held high for several cycles yields exactly one bit sample.
- R3: A falling clock edge clears the detector flag. A data pulse that ends before the clock falls has no effect on the next bit, which reads 0.
- R4: A data pulse (0-to-1 transition on `dat_line`) that arrives after the clock falls and before the next clock rise makes the next bit 1. A data pulse in the same cycle as the clock fall also counts.
- R5: A data pulse in the same cycle as the clock rise counts toward the bit sampled at that rise.
- R6: The cycle after each clock rise taken while `enable` is high, `bit_strobe` is high for exactly one cycle and `bit_value` carries the recovered bit.
- R7: Bits enter the word most significant bit first. When the WORD_BITS-th bit arrives, `word_out` holds the first bit at bit WORD_BITS-1 and the last bit at bit 0.
- R8: While `enable` is low, no bit strobe or word strobe is produced and the bit count is held at zero. A partial word collected before `enable` dropped is discarded.
- R9: `word_valid` is high for one cycle only, in the same cycle as the strobe of every WORD_BITS-th bit counted since `enable` went high. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows bit collection; when low, clears the bit count |
| clk_line | input | 1 | Synchronized clock-reversal pulse line |
| dat_line | input | 1 | Synchronized data-reversal pulse line |
| bit_strobe | output | 1 | One-cycle pulse for each recovered bit |
| bit_value | output | 1 | Recovered bit, valid while `bit_strobe` is high |
| word_out | output | WORD_BITS | Assembled word, MSB first |
| word_valid | output | 1 | One-cycle pulse when `word_out` is updated |

## Verification
The bench covers every 4-bit pattern under four data-pulse placements: mid-cell, together with the clock rise, together with the clock fall, and stale before the fall. A design that sampled the data line level instead of a latched pulse would lose mid-cell ones. One that ignored same-cycle pulses would drop ones at the rise or fall. One that failed to clear on the fall would turn stale pulses into false ones. Between samples, the bench confirms that a clock held high yields no further strobe. A 2-bit partial word is then abandoned by dropping `enable`. A design that kept its count would misalign the following word and strobe `word_valid` early.

// File: rtl/sepclk_bit_recover.sv
module sepclk_bit_recover #(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 clk_line,
  input  logic                 dat_line,
  output logic                 bit_strobe,
  output logic                 bit_value,
  output logic [WORD_BITS-1:0] word_out,
  output logic                 word_valid
);
  localparam int CNT_W = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic                 clk_q, dat_q, det;
  logic [CNT_W-1:0]     cnt;
  logic [WORD_BITS-1:0] shreg, next_sh;
  logic                 clk_rise, clk_fall, dat_rise, bit_now;

  assign clk_rise = clk_line & ~clk_q;
  assign clk_fall = ~clk_line & clk_q;
  assign dat_rise = dat_line & ~dat_q;
  assign bit_now  = det | dat_rise;
  assign next_sh  = {shreg[WORD_BITS-2:0], bit_now};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q      <= 1'b0;
      dat_q      <= 1'b0;
      det        <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
      bit_strobe <= 1'b0;
      bit_value  <= 1'b0;
    end else begin
      clk_q      <= clk_line;
      dat_q      <= dat_line;
      bit_strobe <= 1'b0;
      word_valid <= 1'b0;
      if (clk_fall)      det <= dat_rise;
      else if (dat_rise) det <= 1'b1;
      if (!enable) begin
        cnt <= '0;
      end else if (clk_rise) begin
        bit_strobe <= 1'b1;
        bit_value  <= bit_now;
        shreg      <= next_sh;
        if (cnt == LAST) begin
          cnt        <= '0;
          word_out   <= next_sh;
          word_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sepclk_bit_recover_chk.sv
module sepclk_bit_recover_chk #(
  parameter int WORD_BITS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 clk_line,
  input logic                 dat_line,
  input logic                 clk_q,
  input logic                 dat_q,
  input logic                 bit_strobe,
  input logic                 bit_value,
  input logic [WORD_BITS-1:0] word_out,
  input logic                 word_valid
);
  AST_VALID_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> bit_strobe); // R9
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bit_strobe && !word_valid)); // R8
  AST_COINCIDENT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clk_line && !clk_q && dat_line && !dat_q) |=> (bit_strobe && bit_value)); // R5
  AST_WORD_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_out[0] == bit_value)); // R7
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_line == clk_q) |=> !bit_strobe); // R2
endmodule

bind sepclk_bit_recover sepclk_bit_recover_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .clk_line(clk_line),
  .dat_line(dat_line), .clk_q(clk_q), .dat_q(dat_q), .bit_strobe(bit_strobe),
  .bit_value(bit_value), .word_out(word_out), .word_valid(word_valid)
);

// File: tb/sepclk_bit_recover_test.sv
module sepclk_bit_recover_test;
  localparam int W = 4;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, clk_line = 1'b0, dat_line = 1'b0;
  logic bit_strobe, bit_value, word_valid;
  logic [W-1:0] word_out;
  int checks = 0, fails = 0;
  int exp_cnt = 0;
  logic [W-1:0] exp_sh = '0;

  always #4 clk = ~clk;

  sepclk_bit_recover #(.WORD_BITS(W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_line(clk_line),
    .dat_line(dat_line), .bit_strobe(bit_strobe), .bit_value(bit_value),
    .word_out(word_out), .word_valid(word_valid));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R2/R9 idle strobes", {30'd0, bit_strobe, word_valid}, 32'd0);
    end
  endtask

  // mode 0: mid-cell pulse, 1: with rise, 2: stale before fall, 3: with fall
  task automatic send_bit(input logic b, input int mode);
    logic expb, expv;
    expb = (mode == 2) ? 1'b0 : b;
    if (mode == 2) begin dat_line = b; step(1); dat_line = 1'b0; step(1); end
    clk_line = 1'b0;
    dat_line = (mode == 3) ? b : 1'b0;
    step(1);
    dat_line = 1'b0;
    step(2);
    if (mode == 0) dat_line = b;
    step(1);
    dat_line = 1'b0;
    step(2);
    clk_line = 1'b1;
    dat_line = (mode == 1) ? b : 1'b0;
    @(negedge clk);
    dat_line = 1'b0;
    expv = 1'b0;
    if (enable) begin
      exp_sh = {exp_sh[W-2:0], expb};
      exp_cnt++;
      if (exp_cnt == W) begin expv = 1'b1; exp_cnt = 0; end
      check("R6 strobe", {31'd0, bit_strobe}, 32'd1);
      check(mode == 1 ? "R5 bit" : (mode == 2 ? "R3 bit" : "R4 bit"), {31'd0, bit_value}, {31'd0, expb});
    end else begin
      check("R8 no strobe", {31'd0, bit_strobe}, 32'd0);
    end
    check("R9 word_valid", {31'd0, word_valid}, {31'd0, expv});
    if (expv) check("R7 word", {28'd0, word_out}, {28'd0, exp_sh});
    step(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {28'd0, word_out, bit_strobe, word_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {28'd0, word_out, bit_strobe, word_valid}, 32'd0);
    clk_line = 1'b1;
    step(2);
    enable = 1'b1;
    step(1);
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 16; p++)
        for (int k = W - 1; k >= 0; k--)
          send_bit(p[k], m);
    send_bit(1'b1, 0);
    send_bit(1'b0, 0);
    enable = 1'b0;
    exp_cnt = 0;
    step(1);
    send_bit(1'b1, 0);
    send_bit(1'b1, 1);
    enable = 1'b1;
    step(1);
    send_bit(1'b0, 0); send_bit(1'b1, 0); send_bit(1'b1, 3); send_bit(1'b0, 1);
    check("R8 fresh word after enable", {28'd0, word_out}, 32'h6);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule